// File: doc/BRIEF.md
# Pipeline Hazard Interlock and Operand Bypass Control

This block is the hazard controller of a five-stage integer pipeline (fetch, decode, execute, memory access, write-back). Each cycle it compares the source register numbers of the instruction in decode with the destination numbers of the instructions in execute, memory access and write-back. From that comparison it either lets the front of the pipeline advance or holds it and inserts a bubble. It also gives each ALU operand a bypass select.

A compile-time parameter picks one of two variants. The interlock-only variant resolves every hazard by stalling. The forwarding variant bypasses results to the ALU and stalls only when a load feeds the next instruction.

A second parameter describes the register file timing. By default it writes early in the cycle and reads late. If it instead reads before it writes, a producer in write-back is routed into the decode-to-execute latch input through a separate pair of bypass flags. The register file, ALU and memories are outside the block. The surrounding pipeline feeds it the stage fields and applies its enables and selects.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: In a stall cycle, `pc_en_o` and `ifid_en_o` are 0, `idex_en_o` stays 1 and `idex_bubble_o` is 1. In any other cycle, all three enables are 1 and `idex_bubble_o` is 0. A bubble clears both bypass selects in the following cycle.
- R2: In interlock mode (`FWD_EN`=0), decode stalls while a used, nonzero source matches the write-enabled destination in execute or in memory access. A match in write-back alone does not stall.
- R3: In interlock mode, a load followed by a dependent add, then a subtract that depends on the add, costs two bubbles for each dependency.
- R4: In forwarding mode, an ALU producer never causes a stall. In the cycle after the consumer leaves decode, each operand select reads 2'b01 if the producer was then in execute (take the EX/MEM latch output), 2'b10 if it was in memory access (take the MEM/WB latch output), and 2'b00 otherwise (use the register file value).
- R5: When the destinations in execute and in memory access both match the same source, the select is 2'b01.
- R6: In forwarding mode, a load whose destination is a source of the instruction right behind it causes exactly one bubble. After the bubble, that operand takes 2'b10.
- R7: A source of register 0 never stalls, never produces a nonzero select and never raises a bypass flag.
- R8: With `RF_WR_LATE`=1, `id_byp_a_o` and `id_byp_b_o` are 1 while the write-enabled destination in write-back equals the matching used, nonzero decode source. With `RF_WR_LATE`=0 both flags stay 0.
- R9: In every mode, a pipeline driven by the block's enables and selects gives each instruction the same result that sequential execution gives.
- R10: After reset, with an empty pipeline, all enables are 1, `idex_bubble_o` is 0 and both selects are 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_rs1_i | input | AW | First source register of the instruction in decode |
| id_rs1_use_i | input | 1 | First source is read |
| id_rs2_i | input | AW | Second source register of the instruction in decode |
| id_rs2_use_i | input | 1 | Second source is read |
| ex_rd_i | input | AW | Destination of the instruction in execute |
| ex_wen_i | input | 1 | Instruction in execute writes a register |
| ex_load_i | input | 1 | Instruction in execute is a load |
| mem_rd_i | input | AW | Destination of the instruction in memory access |
| mem_wen_i | input | 1 | Instruction in memory access writes a register |
| wb_rd_i | input | AW | Destination of the instruction in write-back |
| wb_wen_i | input | 1 | Instruction in write-back writes a register |
| pc_en_o | output | 1 | Program counter load enable |
| ifid_en_o | output | 1 | Fetch/decode latch enable |
| idex_en_o | output | 1 | Decode/execute latch enable |
| idex_bubble_o | output | 1 | Zero the control fields entering execute |
| fwd_a_o | output | 2 | ALU operand A select for the instruction in execute |
| fwd_b_o | output | 2 | ALU operand B select for the instruction in execute |
| id_byp_a_o | output | 1 | Route write-back data into the operand A latch input |
| id_byp_b_o | output | 1 | Route write-back data into the operand B latch input |

## Verification
The assertions assume that the stage inputs describe a real pipeline. After a bubble, the execute fields are those of a no-op with `ex_wen_i` low. `ex_load_i` is only raised together with `ex_wen_i`. Each instruction advances one stage per cycle once it is past decode. The bench keeps to this by deriving every stage input from its own pipeline registers, which move only under the block's enables and bubble. Random programs use only registers 0 to 3, so dependencies, register-0 sources and load-use pairs occur often.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_EXMEM = 2'b01,
    FWD_MEMWB = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/hz_src_cmp.sv
`timescale 1ns/1ps
module hz_src_cmp #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic          use_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_wen_i,
  input  logic          ex_load_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_wen_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_wen_i,
  output logic          hit_ex_o,
  output logic          hit_load_o,
  output logic          hit_mem_o,
  output logic          hit_wb_o
);
  logic live;

  // register 0 is hardwired, never a dependency
  assign live       = use_i && (src_i != '0);
  assign hit_ex_o   = live && ex_wen_i  && (ex_rd_i  == src_i);
  assign hit_load_o = hit_ex_o && ex_load_i;
  assign hit_mem_o  = live && mem_wen_i && (mem_rd_i == src_i);
  assign hit_wb_o   = live && wb_wen_i  && (wb_rd_i  == src_i);
endmodule

// File: rtl/hz_decide.sv
`timescale 1ns/1ps
module hz_decide
  import hz_pkg::*;
#(
  parameter int unsigned NS         = 2,
  parameter bit          FWD_EN     = 1'b1,
  parameter bit          RF_WR_LATE = 1'b0
) (
  input  logic [NS-1:0] hit_ex_i,
  input  logic [NS-1:0] hit_load_i,
  input  logic [NS-1:0] hit_mem_i,
  input  logic [NS-1:0] hit_wb_i,
  output logic          stall_o,
  output fwd_sel_e      sel_o [NS],
  output logic [NS-1:0] byp_o
);
  generate
    if (FWD_EN) begin : g_fwd
      // only a load still in execute cannot be bypassed
      assign stall_o = |hit_load_i;
      for (genvar g = 0; g < NS; g++) begin : g_sel
        assign sel_o[g] = hit_ex_i[g]  ? FWD_EXMEM :
                          hit_mem_i[g] ? FWD_MEMWB : FWD_RF;
      end
    end else begin : g_ilock
      assign stall_o = |(hit_ex_i | hit_mem_i | hit_load_i);
      for (genvar g = 0; g < NS; g++) begin : g_sel
        assign sel_o[g] = FWD_RF;
      end
    end
  endgenerate

  // late-write register file: write-back result must enter the ID/EX latch
  assign byp_o = hit_wb_i & {NS{RF_WR_LATE}};
endmodule

// File: rtl/hz_sel_reg.sv
`timescale 1ns/1ps
module hz_sel_reg
  import hz_pkg::*;
#(
  parameter int unsigned NS = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  fwd_sel_e d_i [NS],
  output fwd_sel_e q_o [NS]
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NS; i++) q_o[i] <= FWD_RF;
    end else begin
      for (int i = 0; i < NS; i++) q_o[i] <= clr_i ? FWD_RF : d_i[i];
    end
  end
endmodule

// File: rtl/pipe_hazard_ctl.sv
`timescale 1ns/1ps
module pipe_hazard_ctl
  import hz_pkg::*;
#(
  parameter int unsigned AW         = 5,
  parameter bit          FWD_EN     = 1'b1,
  parameter bit          RF_WR_LATE = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] id_rs1_i,
  input  logic          id_rs1_use_i,
  input  logic [AW-1:0] id_rs2_i,
  input  logic          id_rs2_use_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_wen_i,
  input  logic          ex_load_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_wen_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_wen_i,
  output logic          pc_en_o,
  output logic          ifid_en_o,
  output logic          idex_en_o,
  output logic          idex_bubble_o,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic          id_byp_a_o,
  output logic          id_byp_b_o
);
  localparam int unsigned NS = NUM_SRC;

  logic [AW-1:0] src   [NS];
  logic [NS-1:0] src_use;
  logic [NS-1:0] hit_ex, hit_load, hit_mem, hit_wb, byp;
  logic          stall;
  fwd_sel_e      sel_nxt [NS];
  fwd_sel_e      sel_q   [NS];

  assign src[0]     = id_rs1_i;
  assign src[1]     = id_rs2_i;
  assign src_use[0] = id_rs1_use_i;
  assign src_use[1] = id_rs2_use_i;

  generate
    for (genvar g = 0; g < NS; g++) begin : g_cmp
      hz_src_cmp #(.AW(AW)) u_cmp (
        .src_i     (src[g]),
        .use_i     (src_use[g]),
        .ex_rd_i   (ex_rd_i),
        .ex_wen_i  (ex_wen_i),
        .ex_load_i (ex_load_i),
        .mem_rd_i  (mem_rd_i),
        .mem_wen_i (mem_wen_i),
        .wb_rd_i   (wb_rd_i),
        .wb_wen_i  (wb_wen_i),
        .hit_ex_o  (hit_ex[g]),
        .hit_load_o(hit_load[g]),
        .hit_mem_o (hit_mem[g]),
        .hit_wb_o  (hit_wb[g])
      );
    end
  endgenerate

  hz_decide #(.NS(NS), .FWD_EN(FWD_EN), .RF_WR_LATE(RF_WR_LATE)) u_dec (
    .hit_ex_i  (hit_ex),
    .hit_load_i(hit_load),
    .hit_mem_i (hit_mem),
    .hit_wb_i  (hit_wb),
    .stall_o   (stall),
    .sel_o     (sel_nxt),
    .byp_o     (byp)
  );

  // selects travel with the instruction into execute; a bubble carries none
  hz_sel_reg #(.NS(NS)) u_sel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (stall),
    .d_i   (sel_nxt),
    .q_o   (sel_q)
  );

  assign pc_en_o       = !stall;
  assign ifid_en_o     = !stall;
  assign idex_en_o     = 1'b1;
  assign idex_bubble_o = stall;
  assign fwd_a_o       = sel_q[0];
  assign fwd_b_o       = sel_q[1];
  assign id_byp_a_o    = byp[0];
  assign id_byp_b_o    = byp[1];

  AST_BUBBLE_CLEARS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_bubble_o |=> (fwd_a_o == FWD_RF && fwd_b_o == FWD_RF)); // R1

  AST_R0_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_rs1_i == '0 && id_rs2_i == '0) |-> (!idex_bubble_o && !id_byp_a_o && !id_byp_b_o)); // R7

  generate
    if (FWD_EN) begin : g_ast_fwd
      AST_ALU_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ex_load_i |-> !idex_bubble_o); // R4

      AST_LOAD_USE_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (id_rs1_use_i && id_rs1_i != '0 && ex_wen_i && ex_load_i && ex_rd_i == id_rs1_i)
        |-> idex_bubble_o); // R6

      AST_EXMEM_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!idex_bubble_o && id_rs1_use_i && id_rs1_i != '0 && ex_wen_i && ex_rd_i == id_rs1_i
         && mem_wen_i && mem_rd_i == id_rs1_i) |=> (fwd_a_o == FWD_EXMEM)); // R5
    end else begin : g_ast_ilock
      AST_ILOCK_EX_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (id_rs2_use_i && id_rs2_i != '0 && ex_wen_i && ex_rd_i == id_rs2_i) |-> idex_bubble_o); // R2

      AST_ILOCK_MEM_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (id_rs1_use_i && id_rs1_i != '0 && mem_wen_i && mem_rd_i == id_rs1_i) |-> idex_bubble_o); // R2
    end
  endgenerate
endmodule

// File: tb/sim_pipe_rig.sv
`timescale 1ns/1ps
module sim_pipe_rig #(
  parameter bit FWD  = 1'b1,
  parameter bit LATE = 1'b0
) (
  input logic clk,
  input logic rst_n
);
  localparam int N = 8;
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_LD = 3'd2, OP_ST = 3'd3, OP_NOP = 3'd4;

  logic [2:0]  p_op  [N];
  logic [4:0]  p_rd  [N];
  logic [4:0]  p_rs1 [N];
  logic [4:0]  p_rs2 [N];
  logic [31:0] gold  [N];
  int          plen;
  int          wb_cyc [N];
  int          v_chk, v_fail, p_chk, p_fail;
  int          cyc;

  logic [31:0] rf [32];
  int          pc;
  logic        d_v, e_v, m_v, w_v;
  int          d_i, e_i, m_i, w_i;
  logic [31:0] e_a, e_b, m_res, w_res;

  logic pc_en, ifid_en, idex_en, bub, byp_a, byp_b;
  logic [1:0] fwd_a, fwd_b;

  function automatic logic [2:0] op_at(logic v, int i);
    return v ? p_op[i] : OP_NOP;
  endfunction
  function automatic logic wr_at(logic v, int i);
    logic [2:0] o;
    o = op_at(v, i);
    return (o == OP_ADD) || (o == OP_SUB) || (o == OP_LD);
  endfunction
  function automatic logic [31:0] mem_val(logic [31:0] a);
    return (a & 32'hF) * 5 + 2;
  endfunction
  function automatic logic [31:0] rd_src(logic [4:0] r, logic byp);
    if (r == 5'd0) return 32'd0;
    if (wr_at(w_v, w_i) && p_rd[w_i] == r && (!LATE || byp)) return w_res;
    return rf[r];
  endfunction

  logic [4:0] id_rs1, id_rs2, ex_rd, mem_rd, wb_rd;
  logic       id_use, ex_wen, ex_ld, mem_wen, wb_wen;
  assign id_use  = op_at(d_v, d_i) != OP_NOP;
  assign id_rs1  = d_v ? p_rs1[d_i] : 5'd0;
  assign id_rs2  = d_v ? p_rs2[d_i] : 5'd0;
  assign ex_rd   = e_v ? p_rd[e_i] : 5'd0;
  assign ex_wen  = wr_at(e_v, e_i);
  assign ex_ld   = op_at(e_v, e_i) == OP_LD;
  assign mem_rd  = m_v ? p_rd[m_i] : 5'd0;
  assign mem_wen = wr_at(m_v, m_i);
  assign wb_rd   = w_v ? p_rd[w_i] : 5'd0;
  assign wb_wen  = wr_at(w_v, w_i);

  pipe_hazard_ctl #(.AW(5), .FWD_EN(FWD), .RF_WR_LATE(LATE)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .id_rs1_i(id_rs1), .id_rs1_use_i(id_use), .id_rs2_i(id_rs2), .id_rs2_use_i(id_use),
    .ex_rd_i(ex_rd), .ex_wen_i(ex_wen), .ex_load_i(ex_ld),
    .mem_rd_i(mem_rd), .mem_wen_i(mem_wen), .wb_rd_i(wb_rd), .wb_wen_i(wb_wen),
    .pc_en_o(pc_en), .ifid_en_o(ifid_en), .idex_en_o(idex_en), .idex_bubble_o(bub),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .id_byp_a_o(byp_a), .id_byp_b_o(byp_b)
  );

  logic [31:0] x_a, x_b, x_res;
  always_comb begin
    x_a = (fwd_a == 2'b01) ? m_res : (fwd_a == 2'b10) ? w_res : e_a;
    x_b = (fwd_b == 2'b01) ? m_res : (fwd_b == 2'b10) ? w_res : e_b;
    case (op_at(e_v, e_i))
      OP_SUB:  x_res = x_a - x_b;
      OP_ST:   x_res = 32'd0;
      default: x_res = x_a + x_b;
    endcase
  end

  initial begin v_chk = 0; v_fail = 0; p_chk = 0; p_fail = 0; end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= 0; cyc <= 1;
      d_v <= 1'b0; e_v <= 1'b0; m_v <= 1'b0; w_v <= 1'b0;
      d_i <= 0; e_i <= 0; m_i <= 0; w_i <= 0;
      e_a <= '0; e_b <= '0; m_res <= '0; w_res <= '0;
      for (int k = 0; k < 32; k++) rf[k] <= (k == 0) ? 32'd0 : 32'(k * 3 + 1);
      for (int k = 0; k < N; k++) wb_cyc[k] <= 0;
    end else begin
      cyc <= cyc + 1;
      if (w_v) begin
        wb_cyc[w_i] <= cyc;
        if (wr_at(w_v, w_i) && p_rd[w_i] != 5'd0) begin
          rf[p_rd[w_i]] <= w_res;
          v_chk++;
          if (w_res !== gold[w_i]) begin
            v_fail++;
            $display("FAIL R9 fwd=%0d late=%0d instr %0d result: actual %0d expected %0d",
                     FWD, LATE, w_i, w_res, gold[w_i]);
          end
        end
      end
      w_v <= m_v; w_i <= m_i;
      w_res <= (op_at(m_v, m_i) == OP_LD) ? mem_val(m_res) : m_res;
      m_v <= e_v; m_i <= e_i; m_res <= x_res;
      if (bub) e_v <= 1'b0;
      else begin
        e_v <= d_v; e_i <= d_i;
        e_a <= rd_src(p_rs1[d_i], byp_a);
        e_b <= rd_src(p_rs2[d_i], byp_b);
      end
      if (ifid_en) begin
        d_v <= pc < plen;
        d_i <= (pc < plen) ? pc : 0;
      end
      if (pc_en && pc < plen) pc <= pc + 1;
    end
  end

  // R1: enables and bubble must agree every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      p_chk++;
      if (bub ? (pc_en || ifid_en || !idex_en) : (!pc_en || !ifid_en || !idex_en)) begin
        p_fail++;
        $display("FAIL R1 cycle %0d: actual pc_en=%0d ifid_en=%0d idex_en=%0d bubble=%0d expected enables to match bubble",
                 cyc, pc_en, ifid_en, idex_en, bub);
      end
    end
  end
endmodule

// File: tb/sim_pipe_hazard_ctl.sv
`timescale 1ns/1ps
module sim_pipe_hazard_ctl;
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_LD = 3'd2, OP_ST = 3'd3, OP_NOP = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  sim_pipe_rig #(.FWD(1'b0), .LATE(1'b0)) r_il (.clk(clk), .rst_n(rst_n));
  sim_pipe_rig #(.FWD(1'b1), .LATE(1'b0)) r_fw (.clk(clk), .rst_n(rst_n));
  sim_pipe_rig #(.FWD(1'b1), .LATE(1'b1)) r_lt (.clk(clk), .rst_n(rst_n));

  logic [2:0] t_op [8];
  logic [4:0] t_rd [8], t_rs1 [8], t_rs2 [8];

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(int k, logic [2:0] op, logic [4:0] rd, logic [4:0] a, logic [4:0] b);
    t_op[k] = op; t_rd[k] = rd; t_rs1[k] = a; t_rs2[k] = b;
  endtask

  function automatic logic [31:0] mval(logic [31:0] a);
    return (a & 32'hF) * 5 + 2;
  endfunction

  task automatic load_and_run(int n);
    logic [31:0] r [32];
    logic [31:0] g [8];
    logic [31:0] a, b, v;
    rst_n = 1'b0;
    for (int k = 0; k < 32; k++) r[k] = (k == 0) ? 32'd0 : 32'(k * 3 + 1);
    for (int k = 0; k < n; k++) begin
      a = r[t_rs1[k]]; b = r[t_rs2[k]];
      case (t_op[k])
        OP_SUB:  v = a - b;
        OP_LD:   v = mval(a + b);
        OP_ADD:  v = a + b;
        default: v = 32'd0;
      endcase
      g[k] = v;
      if ((t_op[k] == OP_ADD || t_op[k] == OP_SUB || t_op[k] == OP_LD) && t_rd[k] != 5'd0)
        r[t_rd[k]] = v;
    end
    for (int k = 0; k < 8; k++) begin
      r_il.p_op[k] = t_op[k]; r_il.p_rd[k] = t_rd[k]; r_il.p_rs1[k] = t_rs1[k]; r_il.p_rs2[k] = t_rs2[k];
      r_fw.p_op[k] = t_op[k]; r_fw.p_rd[k] = t_rd[k]; r_fw.p_rs1[k] = t_rs1[k]; r_fw.p_rs2[k] = t_rs2[k];
      r_lt.p_op[k] = t_op[k]; r_lt.p_rd[k] = t_rd[k]; r_lt.p_rs1[k] = t_rs1[k]; r_lt.p_rs2[k] = t_rs2[k];
      r_il.gold[k] = g[k]; r_fw.gold[k] = g[k]; r_lt.gold[k] = g[k];
    end
    r_il.plen = n; r_fw.plen = n; r_lt.plen = n;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_cyc(int c);
    do @(negedge clk); while (r_fw.cyc != c);
  endtask

  task automatic clear_prog();
    for (int k = 0; k < 8; k++) put(k, OP_NOP, 5'd0, 5'd0, 5'd0);
  endtask

  task automatic set_orig();
    clear_prog();
    put(0, OP_LD,  5'd2, 5'd1, 5'd3);
    put(1, OP_ADD, 5'd3, 5'd2, 5'd4);
    put(2, OP_SUB, 5'd1, 5'd3, 5'd4);
    put(3, OP_ADD, 5'd1, 5'd5, 5'd3);
    put(4, OP_ST,  5'd0, 5'd4, 5'd6);
  endtask

  initial begin
    int exp_il [5];
    int exp_fw [5];
    void'($urandom(32'd20511));

    // original order
    set_orig();
    load_and_run(5);
    @(negedge clk);
    chk(r_fw.pc_en && r_fw.ifid_en && r_fw.idex_en && !r_fw.bub, "R10 enables after reset", r_fw.bub, 0);
    chk(r_fw.fwd_a == 2'b00 && r_fw.fwd_b == 2'b00, "R10 selects after reset", r_fw.fwd_a, 0);
    chk(r_il.pc_en && !r_il.bub, "R10 interlock enables after reset", r_il.bub, 0);
    wait_cyc(3);
    chk(r_fw.bub == 1'b1, "R6 load-use bubble cycle 3", r_fw.bub, 1);
    wait_cyc(4);
    chk(r_fw.bub == 1'b0, "R6 single bubble cycle 4", r_fw.bub, 0);
    chk(r_il.bub == 1'b1, "R2 interlock stall with producer in MEM", r_il.bub, 1);
    wait_cyc(5);
    chk(r_fw.fwd_a == 2'b10, "R6 load data from MEM/WB", r_fw.fwd_a, 2);
    wait_cyc(22);
    exp_il = '{5, 8, 11, 12, 13};
    exp_fw = '{5, 7, 8, 9, 10};
    for (int k = 0; k < 5; k++) begin
      chk(r_il.wb_cyc[k] == exp_il[k], $sformatf("R3 interlock WB cycle instr %0d", k), r_il.wb_cyc[k], exp_il[k]);
      chk(r_fw.wb_cyc[k] == exp_fw[k], $sformatf("R6 forward WB cycle instr %0d", k), r_fw.wb_cyc[k], exp_fw[k]);
      chk(r_lt.wb_cyc[k] == exp_fw[k], $sformatf("R6 late-write WB cycle instr %0d", k), r_lt.wb_cyc[k], exp_fw[k]);
    end

    // reordered: load, store, add, sub, add
    clear_prog();
    put(0, OP_LD,  5'd2, 5'd1, 5'd3);
    put(1, OP_ST,  5'd0, 5'd4, 5'd6);
    put(2, OP_ADD, 5'd3, 5'd2, 5'd4);
    put(3, OP_SUB, 5'd1, 5'd3, 5'd4);
    put(4, OP_ADD, 5'd1, 5'd5, 5'd3);
    load_and_run(5);
    wait_cyc(22);
    exp_il = '{5, 6, 8, 11, 12};
    exp_fw = '{5, 6, 7, 8, 9};
    for (int k = 0; k < 5; k++) begin
      chk(r_il.wb_cyc[k] == exp_il[k], $sformatf("R3 interlock reordered WB instr %0d", k), r_il.wb_cyc[k], exp_il[k]);
      chk(r_fw.wb_cyc[k] == exp_fw[k], $sformatf("R6 forward reordered WB instr %0d", k), r_fw.wb_cyc[k], exp_fw[k]);
    end

    // register 0 is never a dependency
    clear_prog();
    put(0, OP_ADD, 5'd0, 5'd1, 5'd2);
    put(1, OP_ADD, 5'd1, 5'd0, 5'd0);
    load_and_run(2);
    wait_cyc(3);
    chk(r_il.bub == 1'b0, "R7 no stall on r0 source", r_il.bub, 0);
    wait_cyc(4);
    chk(r_fw.fwd_a == 2'b00 && r_fw.fwd_b == 2'b00, "R7 no forward on r0", r_fw.fwd_a, 0);
    wait_cyc(12);
    chk(r_il.wb_cyc[1] == 6, "R7 interlock r0 WB cycle", r_il.wb_cyc[1], 6);

    // both EX and MEM hold the source: EX/MEM wins
    clear_prog();
    put(0, OP_ADD, 5'd1, 5'd2, 5'd3);
    put(1, OP_ADD, 5'd1, 5'd1, 5'd2);
    put(2, OP_ADD, 5'd3, 5'd1, 5'd0);
    load_and_run(3);
    wait_cyc(5);
    chk(r_fw.fwd_a == 2'b01, "R5 EX/MEM priority", r_fw.fwd_a, 1);
    chk(r_fw.fwd_b == 2'b00, "R7 r0 operand select", r_fw.fwd_b, 0);
    wait_cyc(14);
    chk(r_fw.wb_cyc[2] == 7, "R4 ALU chain no stall", r_fw.wb_cyc[2], 7);

    // producer two ahead: MEM/WB select, interlock one bubble
    clear_prog();
    put(0, OP_ADD, 5'd1, 5'd2, 5'd3);
    put(1, OP_NOP, 5'd0, 5'd0, 5'd0);
    put(2, OP_ADD, 5'd2, 5'd1, 5'd2);
    load_and_run(3);
    wait_cyc(5);
    chk(r_fw.fwd_a == 2'b10, "R4 MEM/WB select", r_fw.fwd_a, 2);
    wait_cyc(14);
    chk(r_il.wb_cyc[2] == 8, "R2 interlock stall on MEM producer", r_il.wb_cyc[2], 8);
    chk(r_fw.wb_cyc[2] == 7, "R4 forward no stall", r_fw.wb_cyc[2], 7);

    // producer in WB while consumer decodes
    clear_prog();
    put(0, OP_ADD, 5'd1, 5'd2, 5'd3);
    put(1, OP_NOP, 5'd0, 5'd0, 5'd0);
    put(2, OP_NOP, 5'd0, 5'd0, 5'd0);
    put(3, OP_ADD, 5'd2, 5'd1, 5'd1);
    load_and_run(4);
    wait_cyc(5);
    chk(r_lt.byp_a && r_lt.byp_b, "R8 late-write bypass flags", r_lt.byp_a, 1);
    chk(!r_fw.byp_a && !r_fw.byp_b, "R8 write-first bypass idle", r_fw.byp_a, 0);
    chk(r_il.bub == 1'b0, "R2 no stall on WB producer", r_il.bub, 0);
    wait_cyc(14);
    chk(r_il.wb_cyc[3] == 8, "R2 interlock WB cycle", r_il.wb_cyc[3], 8);

    // random programs over a small register set
    for (int t = 0; t < 30; t++) begin
      for (int k = 0; k < 8; k++)
        put(k, 3'($urandom_range(0, 4)), 5'($urandom_range(0, 3)),
            5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)));
      load_and_run(8);
      wait_cyc(36);
      for (int k = 0; k < 8; k++) begin
        chk(r_il.wb_cyc[k] != 0 && r_fw.wb_cyc[k] != 0 && r_lt.wb_cyc[k] != 0,
            $sformatf("R9 instr %0d retired in program %0d", k, t), r_il.wb_cyc[k], 1);
      end
    end

    n_chk  += r_il.v_chk + r_fw.v_chk + r_lt.v_chk + r_il.p_chk + r_fw.p_chk + r_lt.p_chk;
    n_fail += r_il.v_fail + r_fw.v_fail + r_lt.v_fail + r_il.p_fail + r_fw.p_fail + r_lt.p_fail;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule